// File: doc/BRIEF.md
# Fractional-Ratio Clock Enable Generator

This block lets a design that runs on one master clock behave as if a second, unrelated oscillator were present. A phase accumulator adds a programmed 16-bit fraction on every running master cycle. Each carry out of the top bit marks one cycle of the secondary clock. The rate is therefore ratio/65536 of the master rate, held in plain integer fixed point. Two divided enables are derived from the secondary tick: a 1-in-24 enable that drives a sound processor, and a 1-in-768 enable that marks each stereo sample period.

A second counter paces the block against wall time. It issues one millisecond budget after another, each 21477 or 21478 master cycles long. A small remainder accumulator chooses between the two lengths, so the long-run average follows the non-integer number of master cycles per millisecond (21477 and 3/11). Other logic uses the end-of-budget pulse to throttle or to count real time. All outputs are registered and share one clock domain.

Top module: `fracclk_gen`

## Requirements
- R1: While `run_en` is high, every master cycle adds the effective ratio to a 16-bit phase. When that addition carries out of bit 15, `tick_o` is high for exactly one cycle, on the cycle after the edge that performed the addition. In every other case `tick_o` is low.
- R2: While `run_en` is low, the phase does not change, `tick_o` stays low, and neither the tick dividers nor the millisecond pacer advance.
- R3: A value on `ratio_i` sampled at one rising edge becomes the effective ratio for the addition at the next rising edge. A ratio change never clears or alters the accumulated phase.
- R4: The effective ratio is `ratio_i` clamped to the range 0xDF17 to 0xDF8C inclusive. Values below 0xDF17 act as 0xDF17 and values above 0xDF8C act as 0xDF8C.
- R5: While `rst` is high at a rising edge, the phase, the effective ratio (set to 0xDF17), both divider counts and the pacer state are cleared, and every output is low in the following cycle.
- R6: `snd_en_o` is high for one cycle, one cycle after the `tick_o` pulse that is the 24th tick since reset (and every 24th after that).
- R7: `smp_en_o` is high for one cycle, one cycle after the `tick_o` pulse that is the 768th tick since reset (and every 768th after that).
- R8: Millisecond budgets are counted in running master cycles starting at reset. Budget j (j = 0, 1, ...) is 21478 cycles when floor(3j/11) > floor(3(j-1)/11) for j >= 1, and 21477 cycles otherwise. At the running edge that completes a budget, `ms_mark_o` pulses high for the next cycle.
- R9: `ms_long_o` is updated only at the end of a budget. It then shows whether the budget just completed was 21478 cycles long (1) or 21477 (0), and it holds that value until the next end. Its reset value is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Advances phase, dividers and pacer when high |
| ratio_i | input | 16 | Secondary/master rate as a fraction of 65536 |
| tick_o | output | 1 | Secondary clock tick enable |
| snd_en_o | output | 1 | Tick divided by 24 |
| smp_en_o | output | 1 | Tick divided by 768 |
| ms_mark_o | output | 1 | End-of-millisecond-budget pulse |
| ms_long_o | output | 1 | Length of the budget that just completed (1 = 21478) |

## Verification
The hardest case to reach is the end of a long millisecond budget. With the default pacing constants the first 21478-cycle budget is the fifth one, so well over a hundred thousand running cycles must pass with no reset. The stimulus therefore issues its only mid-run reset early. It then keeps `run_en` mostly high through one long random run. During that run it changes the ratio at random intervals, often to values outside the clamp window. A cycle-level reference model checks every output on every cycle. This covers phase continuity across ratio changes and across stalls, as well as the 768-tick sample enable.

// File: rtl/fracclk_pkg.sv
package fracclk_pkg;
  localparam int unsigned RATIO_W      = 16;
  localparam logic [15:0] RATIO_LO     = 16'hdf17;
  localparam logic [15:0] RATIO_HI     = 16'hdf8c;
  localparam int unsigned SND_DIV      = 24;
  localparam int unsigned SMP_DIV      = 768;
  localparam int unsigned MS_BASE      = 21477;
  localparam int unsigned MS_FRAC_NUM  = 3;
  localparam int unsigned MS_FRAC_DEN  = 11;

  typedef enum logic {BUDGET_SHORT = 1'b0, BUDGET_LONG = 1'b1} budget_kind_t;
endpackage

// File: rtl/fracclk_phase.sv
module fracclk_phase #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] LO = '0,
  parameter logic [W-1:0] HI = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_en,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] ratio_q;
  logic [W-1:0] phase_q;
  logic [W-1:0] ratio_lim;
  logic [W:0]   sum;

  always_comb begin
    if (ratio_i < LO)      ratio_lim = LO;
    else if (ratio_i > HI) ratio_lim = HI;
    else                   ratio_lim = ratio_i;
    sum = {1'b0, phase_q} + {1'b0, ratio_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= LO;
      phase_q <= '0;
      tick_o  <= 1'b0;
    end else begin
      ratio_q <= ratio_lim;
      if (run_en) begin
        phase_q <= sum[W-1:0];
        tick_o  <= sum[W];
      end else begin
        tick_o  <= 1'b0;
      end
    end
  end

  // R2: a stalled cycle leaves the phase alone and emits no tick
  p_hold_phase_r2: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> ($stable(phase_q) && !tick_o));
  // R4: the effective ratio never leaves the clamp window
  p_ratio_window_r4: assert property (@(posedge clk) disable iff (rst)
    (ratio_q >= LO) && (ratio_q <= HI));
  // R5: first cycle after reset starts from zero phase and no tick
  p_reset_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phase_q == '0) && !tick_o);
  // R1: a tick is only produced by a running cycle
  p_tick_needs_run_r1: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(run_en));
endmodule

// File: rtl/fracclk_div.sv
module fracclk_div #(
  parameter int unsigned DIV = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic en_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_o  <= 1'b0;
    end else begin
      en_o <= 1'b0;
      if (tick_i) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          en_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R6 (and R7 for the long divider): an enable always follows a tick
  p_en_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
    en_o |-> $past(tick_i));
  // R6: the count never passes the divide limit
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/fracclk_pace.sv
module fracclk_pace
  import fracclk_pkg::*;
#(
  parameter int unsigned BASE = 21477,
  parameter int unsigned NUM  = 3,
  parameter int unsigned DEN  = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic mark_o,
  output logic long_o
);
  localparam int unsigned CW = $clog2(BASE + 2);
  localparam int unsigned FW = $clog2(DEN + NUM + 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(BASE - 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(BASE);

  logic [CW-1:0] cnt_q;
  logic [FW-1:0] frac_q;
  budget_kind_t  kind_q;
  logic [FW-1:0] frac_sum;
  logic          at_end;

  always_comb begin
    frac_sum = frac_q + FW'(NUM);
    at_end   = (kind_q == BUDGET_LONG) ? (cnt_q == LAST_LONG) : (cnt_q == LAST_SHORT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      frac_q <= '0;
      kind_q <= BUDGET_SHORT;
      mark_o <= 1'b0;
      long_o <= 1'b0;
    end else begin
      mark_o <= 1'b0;
      if (run_en) begin
        if (at_end) begin
          cnt_q  <= '0;
          mark_o <= 1'b1;
          long_o <= (kind_q == BUDGET_LONG);
          if (frac_sum >= FW'(DEN)) begin
            frac_q <= frac_sum - FW'(DEN);
            kind_q <= BUDGET_LONG;
          end else begin
            frac_q <= frac_sum;
            kind_q <= BUDGET_SHORT;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8: remainder stays below the denominator
  p_frac_bound_r8: assert property (@(posedge clk) disable iff (rst)
    frac_q < FW'(DEN));
  // R8: count stays within the long budget
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_LONG);
  // R9: budget length flag only moves together with a mark
  p_long_moves_on_mark_r9: assert property (@(posedge clk) disable iff (rst)
    !mark_o |-> $stable(long_o));
  // R2: no mark without a running cycle
  p_mark_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
    mark_o |-> $past(run_en));
endmodule

// File: rtl/fracclk_gen.sv
module fracclk_gen
  import fracclk_pkg::*;
#(
  parameter int unsigned  W        = RATIO_W,
  parameter logic [15:0]  LO       = RATIO_LO,
  parameter logic [15:0]  HI       = RATIO_HI,
  parameter int unsigned  SND      = SND_DIV,
  parameter int unsigned  SMP      = SMP_DIV,
  parameter int unsigned  BASE     = MS_BASE,
  parameter int unsigned  FNUM     = MS_FRAC_NUM,
  parameter int unsigned  FDEN     = MS_FRAC_DEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_en,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o,
  output logic         snd_en_o,
  output logic         smp_en_o,
  output logic         ms_mark_o,
  output logic         ms_long_o
);
  localparam int unsigned NDIV = 2;
  localparam int unsigned DIV_TAB [NDIV] = '{SND, SMP};

  logic            tick_w;
  logic [NDIV-1:0] div_en;

  fracclk_phase #(.W(W), .LO(W'(LO)), .HI(W'(HI))) phase_i (
    .clk(clk), .rst(rst), .run_en(run_en), .ratio_i(ratio_i), .tick_o(tick_w)
  );

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    fracclk_div #(.DIV(DIV_TAB[g])) div_i (
      .clk(clk), .rst(rst), .tick_i(tick_w), .en_o(div_en[g])
    );
  end

  fracclk_pace #(.BASE(BASE), .NUM(FNUM), .DEN(FDEN)) pace_i (
    .clk(clk), .rst(rst), .run_en(run_en), .mark_o(ms_mark_o), .long_o(ms_long_o)
  );

  assign tick_o   = tick_w;
  assign snd_en_o = div_en[0];
  assign smp_en_o = div_en[1];

  // R7: the slow enable coincides with the fast one, as 24 divides 768
  p_smp_with_snd_r7: assert property (@(posedge clk) disable iff (rst)
    smp_en_o |-> snd_en_o);
  // R6: dividers only fire when the phase ran on the previous edge but one
  p_snd_needs_tick_r6: assert property (@(posedge clk) disable iff (rst)
    snd_en_o |-> $past(tick_w));
endmodule

// File: tb/fracclk_gen_tb_top.sv
module fracclk_gen_tb_top;
  localparam int unsigned LO_V = 16'hdf17;
  localparam int unsigned HI_V = 16'hdf8c;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic [15:0] ratio_i = 16'h0000;
  logic tick_o, snd_en_o, smp_en_o, ms_mark_o, ms_long_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fracclk_gen dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .ratio_i(ratio_i),
    .tick_o(tick_o), .snd_en_o(snd_en_o), .smp_en_o(smp_en_o),
    .ms_mark_o(ms_mark_o), .ms_long_o(ms_long_o)
  );

  function automatic logic [15:0] clampv(input logic [15:0] v);
    if (v < 16'(LO_V)) return 16'(LO_V);
    if (v > 16'(HI_V)) return 16'(HI_V);
    return v;
  endfunction

  function automatic bit is_long(input int j);
    if (j == 0) return 1'b0;
    return ((j * 3) / 11) != (((j - 1) * 3) / 11);
  endfunction

  // reference model state
  logic [15:0] m_ratio = 16'(LO_V);
  logic [15:0] m_phase = '0;
  bit m_tick = 0, m_snd = 0, m_smp = 0, m_mark = 0, m_long = 0;
  int m_nticks = 0;
  int m_cyc = 0;
  int m_idx = 0;
  int n_long_marks = 0;
  int n_marks = 0;

  always @(posedge clk) begin
    logic [16:0] s;
    if (rst) begin
      m_ratio = 16'(LO_V); m_phase = '0; m_tick = 0; m_snd = 0; m_smp = 0;
      m_mark = 0; m_long = 0; m_nticks = 0; m_cyc = 0; m_idx = 0;
    end else begin
      m_snd = 0; m_smp = 0;
      if (m_tick) begin
        m_nticks++;
        if (m_nticks % 24 == 0)  m_snd = 1;
        if (m_nticks % 768 == 0) m_smp = 1;
      end
      m_mark = 0;
      if (run_en) begin
        s = {1'b0, m_phase} + {1'b0, m_ratio};
        m_tick = s[16];
        m_phase = s[15:0];
        if (m_cyc == 21477 + int'(is_long(m_idx)) - 1) begin
          m_mark = 1; m_long = is_long(m_idx); m_cyc = 0; m_idx++;
        end else begin
          m_cyc++;
        end
      end else begin
        m_tick = 0;
      end
      m_ratio = clampv(ratio_i);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1,R3,R4 tick_o", tick_o, m_tick);
    chk("R6 snd_en_o", snd_en_o, m_snd);
    chk("R7 smp_en_o", smp_en_o, m_smp);
    chk("R8 ms_mark_o", ms_mark_o, m_mark);
    chk("R9 ms_long_o", ms_long_o, m_long);
    if (ms_mark_o) begin
      n_marks++;
      if (ms_long_o) n_long_marks++;
    end
  endtask

  task automatic pick_ratio();
    int r = int'($urandom_range(0, 9));
    if (r == 0)      ratio_i = 16'h0000;
    else if (r == 1) ratio_i = 16'hffff;
    else if (r == 2) ratio_i = 16'(LO_V - 1);
    else if (r == 3) ratio_i = 16'(HI_V + 1);
    else             ratio_i = 16'($urandom_range(LO_V, HI_V));
  endtask

  task automatic run_cycles(input int n, input int stall_pct);
    int hold = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      if (hold == 0) begin
        pick_ratio();
        hold = int'($urandom_range(1, 60));
      end else begin
        hold--;
      end
      run_en = (int'($urandom_range(0, 99)) >= stall_pct);
    end
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    // R5: outputs during and right after reset
    rst = 1'b1; run_en = 1'b1; ratio_i = 16'hffff;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 tick_o in reset", tick_o, 1'b0);
      chk("R5 snd_en_o in reset", snd_en_o, 1'b0);
      chk("R5 smp_en_o in reset", smp_en_o, 1'b0);
      chk("R5 ms_mark_o in reset", ms_mark_o, 1'b0);
      chk("R5 ms_long_o in reset", ms_long_o, 1'b0);
    end
    // directed R1: first add uses reset ratio 0xDF17, no carry; second uses clamped 0xDF8C, carries
    rst = 1'b0; run_en = 1'b1; ratio_i = 16'hffff;
    @(negedge clk);
    chk("R1 no carry on first add", tick_o, 1'b0);
    @(negedge clk);
    chk("R4 clamped high ratio carries", tick_o, 1'b1);
    // directed R2: stall holds everything
    run_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      compare_all();
    end
    chk("R2 no tick while stalled", tick_o, 1'b0);
    run_en = 1'b1;
    run_cycles(2000, 20);
    // mid-run reset, R5
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R5 tick cleared", tick_o, 1'b0);
    compare_all();
    rst = 1'b0; run_en = 1'b1;
    // long run past the first long budget (R8, R9)
    run_cycles(118000, 5);
    checks++;
    if (n_marks < 5 || n_long_marks != 1) begin
      errors++;
      $display("FAIL R8 budget pattern: actual marks %0d long %0d expected >=5 marks with 1 long",
               n_marks, n_long_marks);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_990_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule